// File: doc/BRIEF.md
# Time-Interleaved SAR Phase Sequencer

This block is the digital control core of an interleaved converter made of sixteen identical successive-approximation sections. A single shared phase counter, clocked on the rising edge of the input clock, assigns each section one slot of a sixteen-cycle schedule. Because the sections are staggered by one cycle, exactly one section samples the input on every clock, and exactly one section hands over its finished result.

Each section's schedule has six kinds of cycle. It samples the zero reference, then runs an auto-zero comparison, then an auto-calibrate comparison. It then samples the input and spends eleven cycles resolving an 11-bit code, most significant bit first. In its last cycle it transfers the code. The comparator, reference ladder and calibration loops sit outside the block. The block drives one-hot strobes for them and a trial code per section. It takes back one comparator decision per section and presents the transferring section's code on a shared result bus.

Top module: `tisar_sequencer`

## Requirements
- R1: A synchronous active-high `rst` forces phase 0 and clears every section's SAR register. A section that transfers before its first post-reset input sample delivers code 0.
- R2: In every cycle each of `zeroRefOh`, `autoZeroOh`, `autoCalOh`, `sampleOh` and `xferOh` has exactly one bit set. Bit k names section k.
- R3: Section k is at local index (phase − k) mod 16, where the phase starts at 0 after reset, rises by one per clock and wraps after 15. The local index selects the section's duty:
  - 0: zero-reference sample.
  - 1: auto-zero.
  - 2: auto-calibrate.
  - 3: input sample.
  - 4 to 14: conversion.
  - 15: transfer.
- R4: In conversion index j, a section's `trialCode` is its kept bits with bit (14 − j) set on top. In the first conversion cycle (j = 4) this is 0x400.
- R5: At the clock edge that ends a conversion cycle, `compIn[k]` = 1 keeps the trial bit and `compIn[k]` = 0 clears it.
- R6: `compIn[k]` has no effect while section k is outside its conversion cycles.
- R7: During a section's transfer cycle, `resultOut` and that section's `trialCode` both equal its final 11-bit code.
- R8: With a comparator that answers (trial ≤ target), the transferred code equals the target, including the end codes 0 and 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all sequencing on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| compIn | input | 16 | Comparator decision per section (1 = input at or above trial) |
| trialCode | output | 176 | Trial code per section, section k in bits [11k+10:11k] |
| zeroRefOh | output | 16 | One-hot: section sampling the zero reference |
| autoZeroOh | output | 16 | One-hot: section running auto-zero |
| autoCalOh | output | 16 | One-hot: section running auto-calibrate |
| sampleOh | output | 16 | One-hot: section sampling the input |
| xferOh | output | 16 | One-hot: section transferring its result |
| resultOut | output | 11 | Code of the transferring section |

## Verification
The bench targets the wrap from phase 15 back to 0. It also covers the sections caught mid-conversion by a reset, which a design that forgot to clear their registers would transfer as stale codes instead of 0. End targets 0 and 2047 catch an off-by-one in the trial-bit position or a reversed keep/clear decision; either fault drops or doubles the lowest or highest bit. Comparator inputs of idle sections are driven with random and all-ones values, so a design that lets an idle decision reach its register corrupts a later result.

// File: rtl/tisar_pkg.sv
package tisar_pkg;
  localparam int RES_BITS  = 11;
  localparam int NUM_SEC   = RES_BITS + 5;
  localparam int PH_W      = $clog2(NUM_SEC);
  localparam int IDX_ZERO  = 0;
  localparam int IDX_AZ    = 1;
  localparam int IDX_CAL   = 2;
  localparam int IDX_SAMP  = 3;
  localparam int IDX_CONV0 = 4;
  localparam int IDX_XFER  = NUM_SEC - 1;

  // Strobes the control hands to the SAR datapath.
  typedef struct packed {
    logic [PH_W-1:0]    phase;
    logic [NUM_SEC-1:0] sampleOh;
    logic [NUM_SEC-1:0] xferOh;
  } ctl_t;

  // Local schedule index of section k at a given phase.
  function automatic logic [PH_W-1:0] localIdx(input logic [PH_W-1:0] ph, input int k);
    int t;
    t = (int'(ph) + NUM_SEC - k) % NUM_SEC;
    return PH_W'(t);
  endfunction
endpackage

// File: rtl/tisar_phase_ctrl.sv
module tisar_phase_ctrl
  import tisar_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  output ctl_t               ctl,
  output logic [NUM_SEC-1:0] zeroRefOh,
  output logic [NUM_SEC-1:0] autoZeroOh,
  output logic [NUM_SEC-1:0] autoCalOh
);
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (phase == PH_W'(NUM_SEC - 1)) phase <= '0;
    else phase <= phase + 1'b1;
  end

  always_comb begin
    ctl.phase = phase;
    for (int k = 0; k < NUM_SEC; k++) begin
      zeroRefOh[k]    = (localIdx(phase, k) == PH_W'(IDX_ZERO));
      autoZeroOh[k]   = (localIdx(phase, k) == PH_W'(IDX_AZ));
      autoCalOh[k]    = (localIdx(phase, k) == PH_W'(IDX_CAL));
      ctl.sampleOh[k] = (localIdx(phase, k) == PH_W'(IDX_SAMP));
      ctl.xferOh[k]   = (localIdx(phase, k) == PH_W'(IDX_XFER));
    end
  end
endmodule

// File: rtl/tisar_sar_bank.sv
module tisar_sar_bank
  import tisar_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  ctl_t                        ctl,
  input  logic [NUM_SEC-1:0]          compIn,
  output logic [NUM_SEC*RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0]         resultOut
);
  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    logic [RES_BITS-1:0] sarReg;
    logic [RES_BITS-1:0] trialMask;
    logic [RES_BITS-1:0] trial;
    logic [PH_W-1:0]     idx;
    logic [PH_W-1:0]     bitPos;
    logic                inConv;

    always_comb begin
      idx       = localIdx(ctl.phase, g);
      inConv    = (idx >= PH_W'(IDX_CONV0)) && (idx < PH_W'(IDX_XFER));
      bitPos    = PH_W'(IDX_XFER - 1) - idx;
      trialMask = inConv ? (RES_BITS'(1) << bitPos) : '0;
      trial     = sarReg | trialMask;
    end

    always_ff @(posedge clk) begin
      if (rst) sarReg <= '0;
      else if (ctl.sampleOh[g]) sarReg <= '0;
      else if (inConv && compIn[g]) sarReg <= trial;
    end

    assign trialCode[g*RES_BITS +: RES_BITS] = trial;
  end

  // AND-OR mux of the one transferring section.
  always_comb begin
    resultOut = '0;
    for (int k = 0; k < NUM_SEC; k++)
      resultOut = resultOut | (trialCode[k*RES_BITS +: RES_BITS] & {RES_BITS{ctl.xferOh[k]}});
  end
endmodule

// File: rtl/tisar_sequencer.sv
module tisar_sequencer
  import tisar_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SEC-1:0]          compIn,
  output logic [NUM_SEC*RES_BITS-1:0] trialCode,
  output logic [NUM_SEC-1:0]          zeroRefOh,
  output logic [NUM_SEC-1:0]          autoZeroOh,
  output logic [NUM_SEC-1:0]          autoCalOh,
  output logic [NUM_SEC-1:0]          sampleOh,
  output logic [NUM_SEC-1:0]          xferOh,
  output logic [RES_BITS-1:0]         resultOut
);
  ctl_t ctl;

  tisar_phase_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ctl(ctl),
    .zeroRefOh(zeroRefOh), .autoZeroOh(autoZeroOh), .autoCalOh(autoCalOh)
  );

  tisar_sar_bank u_bank (
    .clk(clk), .rst(rst), .ctl(ctl), .compIn(compIn),
    .trialCode(trialCode), .resultOut(resultOut)
  );

  assign sampleOh = ctl.sampleOh;
  assign xferOh   = ctl.xferOh;
endmodule

// File: rtl/tisar_sequencer_chk.sv
module tisar_sequencer_chk
  import tisar_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_SEC-1:0]          compIn,
  input logic [NUM_SEC*RES_BITS-1:0] trialCode,
  input logic [NUM_SEC-1:0]          zeroRefOh,
  input logic [NUM_SEC-1:0]          autoZeroOh,
  input logic [NUM_SEC-1:0]          autoCalOh,
  input logic [NUM_SEC-1:0]          sampleOh,
  input logic [NUM_SEC-1:0]          xferOh,
  input logic [RES_BITS-1:0]         resultOut
);
  logic pastValid;
  always_ff @(posedge clk) begin
    if (rst) pastValid <= 1'b0;
    else pastValid <= 1'b1;
  end

  // R2
  onehot_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(zeroRefOh) == 1 && $countones(autoZeroOh) == 1 &&
    $countones(autoCalOh) == 1 && $countones(sampleOh) == 1 && $countones(xferOh) == 1);

  // R3
  sample_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    pastValid |-> sampleOh == (($past(sampleOh) << 1) | ($past(sampleOh) >> (NUM_SEC - 1))));

  // R3
  xfer_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    pastValid |-> zeroRefOh == $past(xferOh));

  // R3
  zero_to_az_chk: assert property (@(posedge clk) disable iff (rst)
    pastValid |-> autoZeroOh == $past(zeroRefOh));

  for (genvar k = 0; k < NUM_SEC; k++) begin : g_msb
    // R4
    first_trial_msb_chk: assert property (@(posedge clk) disable iff (rst)
      (pastValid && $past(sampleOh[k])) |->
        trialCode[k*RES_BITS +: RES_BITS] == (RES_BITS'(1) << (RES_BITS - 1)));
  end

  logic unusedIn;
  assign unusedIn = ^{compIn, autoCalOh, resultOut};
endmodule

bind tisar_sequencer tisar_sequencer_chk u_chk (.*);

// File: tb/tisar_sequencer_tb.sv
module tisar_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int RB = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS-1:0]   compIn = '0;
  logic [NS*RB-1:0] trialCode;
  logic [NS-1:0]   zeroRefOh, autoZeroOh, autoCalOh, sampleOh, xferOh;
  logic [RB-1:0]   resultOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tgtN = 0;
  int mode = 0;
  int tgt [NS];
  bit seen [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  tisar_sequencer u_dut (.*);

  function automatic int idxOf(int c, int k);
    return ((c % NS) - k + NS) % NS;
  endfunction

  function automatic logic [NS-1:0] expOh(int c, int idx);
    logic [NS-1:0] v;
    v = '0;
    for (int k = 0; k < NS; k++) if (idxOf(c, k) == idx) v[k] = 1'b1;
    return v;
  endfunction

  function automatic int nextTgt();
    int v;
    case (tgtN)
      0: v = 0;
      1: v = 2047;
      2: v = 1024;
      3: v = 1023;
      default: v = (tgtN * 733 + 5) % 2048;
    endcase
    tgtN++;
    return v;
  endfunction

  // Expected trial at conversion index j for a given target.
  function automatic int expTrial(int t, int j);
    int b;
    b = 14 - j;
    return ((t >> (b + 1)) << (b + 1)) | (1 << b);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic chkStrobes(int c);
    chk(zeroRefOh  == expOh(c, 0),  "R2/R3 zeroRefOh",  zeroRefOh,  expOh(c, 0));
    chk(autoZeroOh == expOh(c, 1),  "R2/R3 autoZeroOh", autoZeroOh, expOh(c, 1));
    chk(autoCalOh  == expOh(c, 2),  "R2/R3 autoCalOh",  autoCalOh,  expOh(c, 2));
    chk(sampleOh   == expOh(c, 3),  "R2/R3 sampleOh",   sampleOh,   expOh(c, 3));
    chk(xferOh     == expOh(c, 15), "R2/R3 xferOh",     xferOh,     expOh(c, 15));
  endtask

  // At a negedge: check cycle cyc, then drive the comparator for it.
  task automatic step();
    for (int k = 0; k < NS; k++) begin
      int j;
      int tc;
      j = idxOf(cyc, k);
      tc = int'(trialCode[k*RB +: RB]);
      if (j >= 4 && j <= 14) begin
        if (seen[k]) begin
          if (j == 4) chk(tc == 'h400, "R4 first trial MSB", tc, 'h400);
          else chk(tc == expTrial(tgt[k], j), "R4/R5 trial code", tc, expTrial(tgt[k], j));
          compIn[k] = (expTrial(tgt[k], j) <= tgt[k]);
        end else begin
          compIn[k] = 1'b0;
        end
      end else begin
        // R6: idle sections see disturbing comparator values
        case (mode)
          0: compIn[k] = 1'b0;
          1: compIn[k] = 1'($urandom);
          default: compIn[k] = 1'b1;
        endcase
        if (j == 15) begin
          int e;
          e = seen[k] ? tgt[k] : 0;
          chk(int'(resultOut) == e, seen[k] ? "R7/R8 resultOut" : "R1 result before first sample",
              int'(resultOut), e);
          chk(tc == e, "R7 transfer trialCode", tc, e);
        end
        if (j == 3) begin
          tgt[k] = nextTgt();
          seen[k] = 1'b1;
        end
      end
    end
    chkStrobes(cyc);
    @(negedge clk);
    cyc++;
  endtask

  task automatic doReset();
    rst = 1'b1;
    compIn = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state shows phase 0
    chkStrobes(0);
    chk(resultOut == '0, "R1 reset resultOut", int'(resultOut), 0);
    for (int k = 0; k < NS; k++) seen[k] = 1'b0;
    rst = 1'b0;
    cyc = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    for (int k = 0; k < NS; k++) begin tgt[k] = 0; seen[k] = 1'b0; end
    doReset();
    mode = 0;
    repeat (16 * 20) step();
    mode = 1;
    repeat (16 * 20) step();
    mode = 2;
    repeat (16 * 10 + 7) step();
    // R1: reset in the middle of conversions
    doReset();
    mode = 1;
    repeat (16 * 12) step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule